// File: doc/BRIEF.md
# Pulse-Coded Level Link with Loss-of-Signal Timeout

This block moves a single logic level between two clocked halves that share only a pair of pulse lines. The sending half never drives the level itself. It retimes the incoming level through a short synchronizer and waits until the level holds for two consecutive samples. Each accepted change of level then becomes a one-cycle pulse: a `mark` pulse for a change to high and a `space` pulse for a change to low. When the level stays quiet, the sender repeats a pulse that matches the present level at a fixed interval. This lets the receiving half recover its DC state even if an earlier pulse was lost.

The receiving half keeps a two-state latch. A lone `mark` pulse sets it and a lone `space` pulse clears it, and the latch holds its value between pulses. A silence counter runs alongside the latch. Any valid pulse clears the counter and turns the output enable on. If the counter reaches its limit, the enable drops, which marks the far side as dead. After reset, the enable stays off until the first valid pulse arrives. The sender issues one pulse for the present level as soon as its synchronizer is filled.

Inside the top module the two halves are not wired to each other. The transmit pulses leave on output ports and the receive pulses enter on input ports, so the medium between them is external. All time limits are counted in cycles of the single clock.

Top module: `pulse_link_top`

## Requirements
- R1: A change of `line_in` from 0 to 1 that holds for at least two cycles produces exactly one `tx_mark` pulse, one cycle wide. The pulse is visible in the fourth cycle after the change: it is registered on the fourth rising edge after the change.
- R2: A change of `line_in` from 1 to 0 that holds for at least two cycles produces exactly one `tx_space` pulse, one cycle wide, with the same latency as R1.
- R3: `tx_mark` and `tx_space` are never high in the same cycle.
- R4: While `line_in` stays constant, the sender emits a refresh pulse every REFRESH_CYCLES cycles. The refresh is `tx_mark` when the level is 1 and `tx_space` when the level is 0.
- R5: Every change pulse restarts the refresh interval, so the next refresh comes exactly REFRESH_CYCLES cycles after that pulse.
- R6: A change of `line_in` that is sampled once and reverts by the next sample produces no pulse.
- R7: After reset is released, the sender emits exactly one pulse for the present level of `line_in` within eight cycles.
- R8: A cycle with `rx_mark`=1 and `rx_space`=0 makes `line_out`=1 and `line_oe`=1 on the next cycle. A cycle with `rx_space`=1 and `rx_mark`=0 makes `line_out`=0 and `line_oe`=1 on the next cycle.
- R9: In cycles without a valid receive pulse, `line_out` holds its value.
- R10: If WATCHDOG_CYCLES cycles pass after the clock edge that captured the last valid receive pulse, with no further valid pulse, `line_oe` goes to 0 on that edge.
- R11: `line_oe` is 0 during reset. After reset it stays 0 until a valid receive pulse arrives.
- R12: A cycle with `rx_mark` and `rx_space` both high counts as no pulse. It changes neither `line_out` nor `line_oe`.
- R13: Two opposite changes of `line_in` that are two cycles apart produce their pulses in the same order and two cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both halves |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 1 | Asynchronous level to be carried |
| tx_mark | output | 1 | One-cycle pulse: level became or is high |
| tx_space | output | 1 | One-cycle pulse: level became or is low |
| rx_mark | input | 1 | Received high pulse from the medium |
| rx_space | input | 1 | Received low pulse from the medium |
| line_out | output | 1 | Recovered level held by the latch |
| line_oe | output | 1 | 1 while pulses keep arriving; 0 means the output is released |

## Verification
The receive-side properties assume each pulse on `rx_mark` or `rx_space` lasts exactly one cycle, as the sender produces it. They also treat a cycle with both lines high as noise and not as data. The bench holds to these assumptions in two ways. In normal operation it loops the transmit lines straight back into the receive lines. When it drives the receive lines directly, it raises each line for exactly one cycle. The sender's properties assume `line_in` changes at most once per clock cycle. The bench changes `line_in` only at falling edges, and only one line at a time.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;

    // A pair of pulse lines: high pulse and low pulse.
    typedef struct packed {
        logic mark;
        logic space;
    } pulse_pair_t;

    localparam pulse_pair_t PULSE_NONE = '{mark: 1'b0, space: 1'b0};

    function automatic pulse_pair_t pulse_for(input logic level);
        pulse_pair_t p;
        p.mark  = level;
        p.space = ~level;
        return p;
    endfunction

endpackage

// File: rtl/pulse_link_sync.sv
module pulse_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q, chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pulse_link_tx.sv
module pulse_link_tx
    import pulse_link_pkg::*;
#(
    parameter int REFRESH_CYCLES = 24,
    parameter int FILL_CYCLES    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic mark_out,
    output logic space_out
);
    localparam int IDLE_W = $clog2(REFRESH_CYCLES);
    localparam int FILL_W = $clog2(FILL_CYCLES + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(REFRESH_CYCLES - 1);
    localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(FILL_CYCLES);

    typedef struct packed {
        logic              confirm;
        logic              level;
        logic              armed;
        logic [FILL_W-1:0] fill;
        logic [IDLE_W-1:0] idle;
        pulse_pair_t       pulse;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic      steady;

    always_comb begin
        st_d         = st_q;
        st_d.pulse   = PULSE_NONE;
        st_d.confirm = level_in;
        steady       = (level_in == st_q.confirm);

        if (!st_q.armed) begin
            if (st_q.fill == FILL_DONE) begin
                st_d.armed = 1'b1;
                st_d.level = st_q.confirm;
                st_d.pulse = pulse_for(st_q.confirm);
                st_d.idle  = '0;
            end else begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end else if (steady && (st_q.confirm != st_q.level)) begin
            st_d.level = st_q.confirm;
            st_d.pulse = pulse_for(st_q.confirm);
            st_d.idle  = '0;
        end else if (st_q.idle == IDLE_LAST) begin
            st_d.pulse = pulse_for(st_q.level);
            st_d.idle  = '0;
        end else begin
            st_d.idle = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mark_out  = st_q.pulse.mark;
    assign space_out = st_q.pulse.space;

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_out && space_out));
    assert_narrow_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mark_out |=> !mark_out);
    assert_narrow_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
        space_out |=> !space_out);
    assert_idle_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idle <= IDLE_LAST);
endmodule

// File: rtl/pulse_link_rx.sv
module pulse_link_rx #(
    parameter int WATCHDOG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_in,
    input  logic space_in,
    output logic level_out,
    output logic enable_out
);
    localparam int WD_W = $clog2(WATCHDOG_CYCLES);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WATCHDOG_CYCLES - 1);

    typedef struct packed {
        logic            level;
        logic            enable;
        logic [WD_W-1:0] silence;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      valid;

    always_comb begin
        st_d  = st_q;
        valid = mark_in ^ space_in;
        if (valid) begin
            st_d.level   = mark_in;
            st_d.enable  = 1'b1;
            st_d.silence = '0;
        end else if (st_q.silence == WD_LAST) begin
            st_d.enable = 1'b0;
        end else begin
            st_d.silence = st_q.silence + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_out  = st_q.level;
    assign enable_out = st_q.enable;

    assert_pulse_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_in ^ space_in) |=> enable_out);
    assert_mark_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_in && !space_in) |=> level_out);
    assert_space_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (space_in && !mark_in) |=> !level_out);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_in ^ space_in) |=> $stable(level_out));
    assert_stay_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_out && !(mark_in ^ space_in)) |=> !enable_out);
    assert_wd_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.silence <= WD_LAST);
endmodule

// File: rtl/pulse_link_top.sv
module pulse_link_top #(
    parameter int SYNC_STAGES     = 2,
    parameter int REFRESH_CYCLES  = 24,
    parameter int WATCHDOG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic tx_mark,
    output logic tx_space,
    input  logic rx_mark,
    input  logic rx_space,
    output logic line_out,
    output logic line_oe
);
    localparam int FILL_CYCLES = SYNC_STAGES + 1;

    logic level_sync;

    pulse_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (level_sync)
    );

    pulse_link_tx #(
        .REFRESH_CYCLES (REFRESH_CYCLES),
        .FILL_CYCLES    (FILL_CYCLES)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (level_sync),
        .mark_out  (tx_mark),
        .space_out (tx_space)
    );

    pulse_link_rx #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_in    (rx_mark),
        .space_in   (rx_space),
        .level_out  (line_out),
        .enable_out (line_oe)
    );
endmodule

// File: tb/tb_pulse_link_top.sv
module tb_pulse_link_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF = 24;
    localparam int WD  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic tx_mark, tx_space, line_out, line_oe;
    logic cut = 1'b0, bb_mark = 1'b0, bb_space = 1'b0;
    wire  rx_mark  = cut ? bb_mark  : tx_mark;
    wire  rx_space = cut ? bb_space : tx_space;

    pulse_link_top #(.SYNC_STAGES(2), .REFRESH_CYCLES(REF), .WATCHDOG_CYCLES(WD)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .tx_mark(tx_mark), .tx_space(tx_space),
        .rx_mark(rx_mark), .rx_space(rx_space),
        .line_out(line_out), .line_oe(line_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int n_mark = 0, n_space = 0;
    int last_t = -1, prev_t = -1, last_mark_t = -1, last_space_t = -1;
    int checks = 0, errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_mark && tx_space) begin
                checks++; errors++;
                $display("FAIL R3: both pulse lines high at cycle %0d (actual 1, expected 0)", cyc);
            end
            if (tx_mark)  begin n_mark++;  last_mark_t  = cyc; end
            if (tx_space) begin n_space++; last_space_t = cyc; end
            if (tx_mark || tx_space) begin prev_t = last_t; last_t = cyc; end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // {level, mark count, space count, expected line_out}
    localparam int NV = 7;
    localparam logic [5:0] VEC [NV] = '{
        {1'b0, 2'd0, 2'd1, 1'b0},
        {1'b0, 2'd0, 2'd0, 1'b0},
        {1'b1, 2'd1, 2'd0, 1'b1},
        {1'b1, 2'd0, 2'd0, 1'b1},
        {1'b0, 2'd0, 2'd1, 1'b0},
        {1'b1, 2'd1, 2'd0, 1'b1},
        {1'b0, 2'd0, 2'd1, 1'b0}
    };

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int bm, bs;
        int c;
        line_in = 1'b1;
        tick(3);
        check(line_oe == 1'b0, "R11 enable off in reset", line_oe, 0);
        rst_n = 1'b1;
        tick(1);
        check(line_oe == 1'b0, "R11 enable off before first pulse", line_oe, 0);
        bm = n_mark; bs = n_space;
        tick(8);
        check(n_mark - bm == 1, "R7 boot mark count", n_mark - bm, 1);
        check(n_space - bs == 0, "R7 boot space count", n_space - bs, 0);
        check(line_oe == 1'b1 && line_out == 1'b1, "R8 latch after boot", {line_oe, line_out}, 3);

        // table walk: R1 R2 R8 R9
        for (int i = 0; i < NV; i++) begin
            bm = n_mark; bs = n_space;
            line_in = VEC[i][5];
            tick(10);
            check(n_mark - bm == int'(VEC[i][4:3]), $sformatf("R1 vec%0d marks", i), n_mark - bm, int'(VEC[i][4:3]));
            check(n_space - bs == int'(VEC[i][2:1]), $sformatf("R2 vec%0d spaces", i), n_space - bs, int'(VEC[i][2:1]));
            check(line_out == VEC[i][0], $sformatf("R9 vec%0d line_out", i), line_out, VEC[i][0]);
        end

        // refresh and latency: R1 R4
        bm = n_mark; bs = n_space;
        c = cyc;
        line_in = 1'b1;
        tick(4 + 2*REF);
        check(prev_t == c + 4 + REF, "R4 first refresh time", prev_t, c + 4 + REF);
        check(last_t == c + 4 + 2*REF, "R4 second refresh time", last_t, c + 4 + 2*REF);
        check(n_mark - bm == 3 && n_space == bs, "R4 refresh polarity", n_mark - bm, 3);

        // order and interval restart: R13 R5
        c = cyc;
        line_in = 1'b0;
        tick(2);
        line_in = 1'b1;
        tick(4);
        check(last_space_t == c + 4, "R13 space pulse first", last_space_t, c + 4);
        check(last_mark_t == c + 6, "R13 mark pulse second", last_mark_t, c + 6);
        tick(REF);
        check(last_mark_t == c + 6 + REF, "R5 refresh restarted", last_mark_t, c + 6 + REF);

        // one-sample glitch: R6
        bs = n_space;
        line_in = 1'b0;
        tick(1);
        line_in = 1'b1;
        tick(8);
        check(n_space == bs, "R6 glitch filtered", n_space - bs, 0);
        check(line_out == 1'b1, "R6 output unchanged", line_out, 1);

        // watchdog: R10 R9
        cut = 1'b1;
        tick(1);
        bb_mark = 1'b1;
        tick(1);
        bb_mark = 1'b0;
        tick(WD - 1);
        check(line_oe == 1'b1, "R10 enable held before limit", line_oe, 1);
        check(line_out == 1'b1, "R9 level held while silent", line_out, 1);
        tick(1);
        check(line_oe == 1'b0, "R10 enable dropped at limit", line_oe, 0);

        // both lines together ignored: R12, then R11 stays off
        bb_mark = 1'b1; bb_space = 1'b1;
        tick(1);
        bb_mark = 1'b0; bb_space = 1'b0;
        tick(2);
        check(line_oe == 1'b0, "R12 dual pulse no enable", line_oe, 0);
        check(line_out == 1'b1, "R12 dual pulse no level change", line_out, 1);
        check(line_oe == 1'b0, "R11 stays off without pulse", line_oe, 0);

        // lone space pulse: R8
        bb_space = 1'b1;
        tick(1);
        bb_space = 1'b0;
        check(line_oe == 1'b1 && line_out == 1'b0, "R8 space re-enables low", {line_oe, line_out}, 2);

        cut = 1'b0;
        tick(2*REF);
        check(line_oe == 1'b1 && line_out == 1'b1, "R4 loop recovers level", {line_oe, line_out}, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule